// File: doc/BRIEF.md
# Serial Transmitter with Deferred Disable

This block sends asynchronous serial characters. Each character has one low start bit, 5 to 9 data bits sent least-significant first, and one high stop bit. The line moves to the next bit on each pulse of an external baud tick. A one-entry holding buffer sits in front of a shift register, so software can queue the next character while the current one is on the wire. The buffer-empty and done flags each pass through a mask to give an interrupt request.

A control word turns the transmitter on and off. It also holds the two interrupt masks, the top bit of the character-size code and the ninth data bit. While the transmitter owns the serial line it drives the line. Otherwise the line follows a default port value. Turning the transmitter off is deferred: the block keeps the line and finishes every character already accepted before it lets go.

Top module: `uart_tx_deferred`

## Requirements
- R1: After reset all control bits are 0. The line is released (`txd` equals `portIdle`, `lineOwned` is 0), `bufEmpty` is 1, `txDone` is 0 and both interrupt requests are 0.
- R2: A frame is a low start bit, then the data bits starting with bit 0, then a high stop bit. Each bit is held until the next `baudTick`. The start bit appears on `txd` in the cycle after the character moves into the shift register.
- R3: The size code is {`ctrlWrData[3]` as stored, `sizeLow[1:0]`}. It selects the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8, 111 gives 9, and any other code gives 8. The code is sampled when a character moves into the shift register.
- R4: The ninth data bit is the stored `ctrlWrData[4]` at the moment of the data write. Changing that control bit later does not change a character already accepted.
- R5: An accepted data write clears `bufEmpty` on the next edge. If the shift register is idle, the character moves into it one edge later and `bufEmpty` returns to 1. A second character may be written while the first is being sent, and the two frames go out back to back.
- R6: A data write is ignored while the buffer is full or while the enable bit `ctrlWrData[0]` is 0. No frame is sent for it and `bufEmpty` does not change.
- R7: Clearing the enable bit leaves `lineOwned` at 1 until both the buffer and the shift register are empty. From then on `txd` follows `portIdle`.
- R8: `txDone` becomes 1 when a stop bit ends and the buffer is empty. It stays 0 when another character is waiting. It clears on `doneClr` or on `doneIrqAck`.
- R9: `emptyIrq` is 1 only when the empty mask `ctrlWrData[1]`, `globalIrqEn` and `bufEmpty` are all 1.
- R10: `doneIrq` is 1 only when the done mask `ctrlWrData[2]`, `globalIrqEn` and `txDone` are all 1.
- R11: While the line is owned and no frame is in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrEn | input | 1 | Writes the control word |
| ctrlWrData | input | 5 | Control: [0] enable, [1] empty mask, [2] done mask, [3] size high bit, [4] ninth bit |
| sizeLow | input | 2 | Low two bits of the size code |
| dataWrEn | input | 1 | Writes a character into the buffer |
| dataWrData | input | 8 | Low eight data bits |
| baudTick | input | 1 | One-cycle pulse per bit time |
| globalIrqEn | input | 1 | Global interrupt enable |
| doneClr | input | 1 | Clears the done flag (write one) |
| doneIrqAck | input | 1 | Done interrupt acknowledge, also clears the flag |
| portIdle | input | 1 | Value placed on the line when it is released |
| txd | output | 1 | Serial output |
| lineOwned | output | 1 | Transmitter is driving the line |
| bufEmpty | output | 1 | Holding buffer is free |
| txDone | output | 1 | Transmission finished with nothing pending |
| emptyIrq | output | 1 | Buffer-empty interrupt request |
| doneIrq | output | 1 | Done interrupt request |

## Verification
The assertions watch on every cycle:
- the line stays owned while work is pending, and follows the port value once released;
- the line is high while owned and idle;
- the start bit appears as the buffer empties into the shifter;
- the buffer only fills after a write;
- the done flag only rises with nothing pending;
- interrupts stay silent without the global enable.

Only the bench scenarios can show:
- the bit order and frame length for each size code;
- that the ninth bit is captured at write time;
- that writes into a full buffer or a disabled block are dropped;
- that back-to-back frames hold off the done flag until the last stop bit.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MAX_BITS = BYTE_W + 1;
  localparam int unsigned FRAME_W = MAX_BITS + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned CTRL_W  = 5;

  // control word bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_EMPTY = 1;
  localparam int unsigned CB_DONE  = 2;
  localparam int unsigned CB_SZHI  = 3;
  localparam int unsigned CB_NINTH = 4;

  typedef struct packed {
    logic bufWrite;
    logic shiftLoad;
  } utx_strobe_t;

  typedef struct packed {
    logic shiftBusy;
    logic stopDone;
  } utx_status_t;

  function automatic logic [CNT_W-1:0] decodeSize(input logic [2:0] code);
    case (code)
      3'b000:  decodeSize = CNT_W'(5);
      3'b001:  decodeSize = CNT_W'(6);
      3'b010:  decodeSize = CNT_W'(7);
      3'b111:  decodeSize = CNT_W'(9);
      default: decodeSize = CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  utx_strobe_t       strobe,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              ninthIn,
  input  logic [2:0]        sizeCode,
  input  logic              baudTick,
  output utx_status_t       status,
  output logic              lineBit
);
  logic [MAX_BITS-1:0] bufData;
  logic [FRAME_W-1:0]  shiftReg;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    bitsLeft;
  logic [CNT_W-1:0]    nBits;
  logic                busy;

  assign nBits = decodeSize(sizeCode);

  // assemble start, data and stop (unused upper positions stay high)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < int'(MAX_BITS); i++) begin
      if (i < int'(nBits)) frame[i+1] = bufData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufData <= '0;
    else if (strobe.bufWrite) bufData <= {ninthIn, dataIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      busy     <= 1'b0;
    end else if (strobe.shiftLoad) begin
      shiftReg <= frame;
      bitsLeft <= nBits + CNT_W'(2);
      busy     <= 1'b1;
    end else if (busy && baudTick) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - CNT_W'(1);
      if (bitsLeft == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign status.shiftBusy = busy;
  assign status.stopDone  = busy && baudTick && (bitsLeft == CNT_W'(1));
  assign lineBit          = busy ? shiftReg[0] : 1'b1;
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic [1:0]        sizeLow,
  input  logic              dataWrEn,
  input  logic              doneClr,
  input  logic              doneIrqAck,
  input  logic              globalIrqEn,
  input  utx_status_t       status,
  output utx_strobe_t       strobe,
  output logic [2:0]        sizeCode,
  output logic              ninthBit,
  output logic              lineOwned,
  output logic              bufEmpty,
  output logic              txDone,
  output logic              emptyIrq,
  output logic              doneIrq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              bufFull;
  logic              doneFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWrEn) ctrlReg <= ctrlWrData;
  end

  assign strobe.shiftLoad = bufFull && !status.shiftBusy;
  assign strobe.bufWrite  = dataWrEn && ctrlReg[CB_EN] && !bufFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufFull <= 1'b0;
    else if (strobe.bufWrite) bufFull <= 1'b1;
    else if (strobe.shiftLoad) bufFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneFlag <= 1'b0;
    else if (status.stopDone && !bufFull) doneFlag <= 1'b1;
    else if (doneClr || doneIrqAck) doneFlag <= 1'b0;
  end

  assign sizeCode  = {ctrlReg[CB_SZHI], sizeLow};
  assign ninthBit  = ctrlReg[CB_NINTH];
  assign lineOwned = ctrlReg[CB_EN] || bufFull || status.shiftBusy;
  assign bufEmpty  = !bufFull;
  assign txDone    = doneFlag;
  assign emptyIrq  = ctrlReg[CB_EMPTY] && globalIrqEn && !bufFull;
  assign doneIrq   = ctrlReg[CB_DONE] && globalIrqEn && doneFlag;
endmodule

// File: rtl/uart_tx_deferred.sv
module uart_tx_deferred
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic [1:0]        sizeLow,
  input  logic              dataWrEn,
  input  logic [BYTE_W-1:0] dataWrData,
  input  logic              baudTick,
  input  logic              globalIrqEn,
  input  logic              doneClr,
  input  logic              doneIrqAck,
  input  logic              portIdle,
  output logic              txd,
  output logic              lineOwned,
  output logic              bufEmpty,
  output logic              txDone,
  output logic              emptyIrq,
  output logic              doneIrq
);
  utx_strobe_t strobe;
  utx_status_t dpStatus;
  logic [2:0]  sizeCode;
  logic        ninthBit;
  logic        lineBit;
  logic        shiftBusy;

  utx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .sizeLow(sizeLow), .dataWrEn(dataWrEn), .doneClr(doneClr),
    .doneIrqAck(doneIrqAck), .globalIrqEn(globalIrqEn), .status(dpStatus),
    .strobe(strobe), .sizeCode(sizeCode), .ninthBit(ninthBit),
    .lineOwned(lineOwned), .bufEmpty(bufEmpty), .txDone(txDone),
    .emptyIrq(emptyIrq), .doneIrq(doneIrq)
  );

  utx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataWrData),
    .ninthIn(ninthBit), .sizeCode(sizeCode), .baudTick(baudTick),
    .status(dpStatus), .lineBit(lineBit)
  );

  assign shiftBusy = dpStatus.shiftBusy;
  assign txd       = lineOwned ? lineBit : portIdle;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rstN,
  input logic txd,
  input logic lineOwned,
  input logic bufEmpty,
  input logic txDone,
  input logic emptyIrq,
  input logic doneIrq,
  input logic globalIrqEn,
  input logic dataWrEn,
  input logic portIdle,
  input logic shiftBusy
);
  assert_start_on_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> (txd == 1'b0));

  assert_fill_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> $past(dataWrEn));

  assert_owned_while_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEmpty || shiftBusy) |-> lineOwned);

  assert_released_follows_port_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lineOwned |-> (txd == portIdle));

  assert_done_rise_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> (bufEmpty && !shiftBusy));

  assert_irq_global_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> (!emptyIrq && !doneIrq));

  assert_done_irq_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> txDone);

  assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lineOwned && !shiftBusy) |-> txd);
endmodule

bind uart_tx_deferred utx_checker u_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .lineOwned(lineOwned),
  .bufEmpty(bufEmpty), .txDone(txDone), .emptyIrq(emptyIrq),
  .doneIrq(doneIrq), .globalIrqEn(globalIrqEn), .dataWrEn(dataWrEn),
  .portIdle(portIdle), .shiftBusy(shiftBusy)
);

// File: tb/uart_tx_deferred_tb.sv
module uart_tx_deferred_tb;
  logic       clk = 0, rstN = 0;
  logic       ctrlWrEn = 0, dataWrEn = 0, baudTick = 0;
  logic [4:0] ctrlWrData = '0;
  logic [1:0] sizeLow = 2'b11;
  logic [7:0] dataWrData = '0;
  logic       globalIrqEn = 0, doneClr = 0, doneIrqAck = 0, portIdle = 0;
  logic       txd, lineOwned, bufEmpty, txDone, emptyIrq, doneIrq;

  typedef struct { logic [10:0] bits; int n; string tag; } expFrame_t;
  expFrame_t q[$];
  expFrame_t cur;
  int  checks = 0, errors = 0, idx = 0;
  bit  inFrame = 0;
  logic [4:0] cfg = '0;

  uart_tx_deferred u_dut (.*);

  initial forever #5 clk = ~clk;

  initial begin : baudGen
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 4;
      baudTick = (cnt == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic int expSize(input logic [2:0] code);
    case (code)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  // monitor: pops an expected frame at each start bit, compares every bit
  initial forever begin
    @(negedge clk); #1;
    if (baudTick) begin
      if (!inFrame) begin
        if (lineOwned && txd == 1'b0) begin
          if (q.size() == 0) eq("R6 unexpected frame", 1, 0);
          else begin
            cur = q.pop_front();
            idx = 1;
            inFrame = 1;
          end
        end
      end else begin
        eq(cur.tag, int'(txd), int'(cur.bits[idx]));
        idx++;
        if (idx == cur.n) inFrame = 0;
      end
    end
  end

  task automatic ctrlWrite(input logic [4:0] v);
    @(negedge clk);
    ctrlWrEn = 1; ctrlWrData = v; cfg = v;
    @(negedge clk);
    ctrlWrEn = 0;
  endtask

  // driver: pushes the expected frame into the scoreboard when accepted
  task automatic writeData(input logic [7:0] d, input bit accept, input string tag);
    expFrame_t f;
    int n;
    n = expSize({cfg[3], sizeLow});
    f.bits = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < n; i++) f.bits[i+1] = (i < 8) ? d[i] : cfg[4];
    f.n = n + 2;
    f.tag = tag;
    if (accept) q.push_back(f);
    @(negedge clk);
    dataWrEn = 1; dataWrData = d;
    @(negedge clk);
    dataWrEn = 0;
  endtask

  task automatic waitIdle();
    while (q.size() != 0 || inFrame) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseClr(input bit viaAck);
    @(negedge clk);
    if (viaAck) doneIrqAck = 1; else doneClr = 1;
    @(negedge clk);
    doneIrqAck = 0; doneClr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    globalIrqEn = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    eq("R1 txd released", int'(txd), 0);
    eq("R1 lineOwned", int'(lineOwned), 0);
    eq("R1 bufEmpty", int'(bufEmpty), 1);
    eq("R1 txDone", int'(txDone), 0);
    eq("R1 irqs", int'(emptyIrq | doneIrq), 0);

    // R6 write while disabled is dropped
    writeData(8'hA5, 0, "R6");
    eq("R6 disabled write bufEmpty", int'(bufEmpty), 1);
    eq("R6 disabled txd", int'(txd), 0);

    // enable, 8-bit size
    sizeLow = 2'b11;
    ctrlWrite(5'b00001);
    eq("R11 idle high", int'(txd), 1);
    eq("R7 owned when enabled", int'(lineOwned), 1);

    // R5 buffer handoff timing
    writeData(8'h3C, 1, "R2 frame 8-bit");
    eq("R5 bufEmpty low after write", int'(bufEmpty), 0);
    @(negedge clk);
    eq("R5 bufEmpty back after load", int'(bufEmpty), 1);
    waitIdle();
    eq("R8 done after stop", int'(txDone), 1);
    pulseClr(0);
    eq("R8 cleared by doneClr", int'(txDone), 0);

    // R3 size codes
    sizeLow = 2'b00; ctrlWrite(5'b00001);
    writeData(8'h0B, 1, "R3 size 5");  waitIdle(); pulseClr(1);
    eq("R8 cleared by ack", int'(txDone), 0);
    sizeLow = 2'b01; ctrlWrite(5'b00001);
    writeData(8'h15, 1, "R3 size 6");  waitIdle(); pulseClr(0);
    sizeLow = 2'b10; ctrlWrite(5'b00001);
    writeData(8'h2A, 1, "R3 size 7");  waitIdle(); pulseClr(0);
    sizeLow = 2'b00; ctrlWrite(5'b01001);
    writeData(8'hC3, 1, "R3 code 100 as 8"); waitIdle(); pulseClr(0);

    // R4 nine-bit frames, ninth bit captured at write
    sizeLow = 2'b11; ctrlWrite(5'b11001);
    writeData(8'h5A, 1, "R4 ninth one");
    ctrlWrite(5'b01001);
    waitIdle(); pulseClr(0);
    writeData(8'hFF, 1, "R4 ninth zero"); waitIdle(); pulseClr(0);

    // R5/R6 back-to-back, write into full buffer dropped
    ctrlWrite(5'b00001);
    writeData(8'h81, 1, "R5 first of pair");
    writeData(8'h7E, 1, "R5 second of pair");
    eq("R5 buffer holds second", int'(bufEmpty), 0);
    writeData(8'h55, 0, "R6");
    eq("R6 full buffer unchanged", int'(bufEmpty), 0);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    eq("R8 no done while pending", int'(txDone), 0);
    waitIdle();
    eq("R8 done after pair", int'(txDone), 1);
    pulseClr(0);

    // R7 deferred disable
    portIdle = 0;
    writeData(8'hE7, 1, "R7 frame A");
    writeData(8'h18, 1, "R7 frame B");
    ctrlWrite(5'b00000);
    eq("R7 still owned after disable", int'(lineOwned), 1);
    waitIdle();
    eq("R7 released after drain", int'(lineOwned), 0);
    eq("R7 txd follows port low", int'(txd), 0);
    portIdle = 1;
    @(negedge clk);
    eq("R7 txd follows port high", int'(txd), 1);

    // R9 empty interrupt gating
    ctrlWrite(5'b00011);
    eq("R9 empty irq on", int'(emptyIrq), 1);
    globalIrqEn = 0;
    @(negedge clk);
    eq("R9 empty irq global off", int'(emptyIrq), 0);
    globalIrqEn = 1;
    writeData(8'h42, 1, "R2 frame irq");
    eq("R9 empty irq while full", int'(emptyIrq), 0);
    waitIdle();

    // R10 done interrupt gating
    eq("R10 done irq masked", int'(doneIrq), 0);
    ctrlWrite(5'b00101);
    eq("R10 done irq on", int'(doneIrq), 1);
    globalIrqEn = 0;
    @(negedge clk);
    eq("R10 done irq global off", int'(doneIrq), 0);
    globalIrqEn = 1;
    pulseClr(1);
    eq("R10 done irq after ack", int'(doneIrq), 0);

    repeat (10) @(negedge clk);
    eq("R6 no leftover frames", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule